// File: doc/BRIEF.md
# Two-Level Interrupt Event Aggregator

This block sits between one peripheral and a top-level interrupt controller. The peripheral raises single-cycle event pulses, one wire per source. Each pulse is caught in a per-source pending bit, and that bit stays set until software acknowledges it. A per-source enable register masks the pending bits. The masked bits are ORed into one level-sensitive request line for the top-level controller.

Pending bits are captured whether or not their source is enabled. A fresh event always wins over a software clear that lands in the same cycle. Events are not counted. When an enabled source fires again while its pending bit is still set, the second event is dropped, and a sticky per-source lost-event bit records the loss.

Software reaches the three registers through a small synchronous bus. A write completes in one cycle. A read returns its data one cycle after the read strobe. The number of sources is a parameter between 1 and 32.

Top module: `irq_event_collector`

## Requirements
- R1: A pulse on `evt_in[i]` sets pending bit i at the next clock edge, whatever the value of enable bit i.
- R2: A write to the pending register (word offset 0) clears every pending bit whose data bit is 1. Bits written with 0 keep their value.
- R3: When an event on source i and a clear of pending bit i occur in the same cycle, pending bit i is 1 after that edge.
- R4: The enable register (word offset 1) is a plain read/write mask: bit i becomes the written data bit i. It changes no pending bit or lost-event bit.
- R5: `irq_req` is the OR over all sources of (pending AND enable), taken from the registered state. It stays 1 until every enabled pending bit is cleared or masked.
- R6: Writing 1 to an enable bit whose pending bit is already set makes `irq_req` 1 right after that write's clock edge.
- R7: An event on source i whose pending bit is 1, whose enable bit is 1 and which is not being cleared in that cycle sets lost-event bit i. An event on a clear pending bit, or on a masked source, sets no lost-event bit.
- R8: Lost-event bits (word offset 2) are sticky. Writing 1 clears a bit and writing 0 has no effect. When a new loss coincides with a clear of the same bit, the bit is 1 afterwards.
- R9: After reset, all pending, enable and lost-event bits are 0 and `irq_req` is 0.
- R10: A read strobe with a word offset of 0, 1 or 2 returns that register on `bus_rdata` one cycle later. Bits at or above NUM_SRC read 0. Offset 3 reads 0, and a write to offset 3 changes nothing. Reads change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | NUM_SRC | Single-cycle event pulses, one per source |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Word offset: 0 pending, 1 enable, 2 lost-event |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_req | output | 1 | Level-sensitive request to the top-level controller |

## Verification
A change in a pending, enable or lost-event bit takes effect at the clock edge where its event or write is sampled. `irq_req` follows that change right after the same edge, because no register sits behind the mask-and-OR. Read data is due one edge after the strobe.

The bench drives its inputs and checks its outputs on falling edges. A behavioural model advances on each rising edge. Every falling edge compares `irq_req` with the model, and the same falling edge that follows a read strobe compares `bus_rdata` with the register value the model captured when the strobe was sampled.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 2;
    localparam int MAX_SRC = 32;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PEND   = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_LOST   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // Decoded write request passed from the bus port to the storage.
    typedef struct packed {
        logic             pend_clr_we;
        logic             enable_we;
        logic             lost_clr_we;
        logic [BUS_W-1:0] data;
    } reg_wr_t;

    // Per-source next-state inputs for one cell.
    typedef struct packed {
        logic evt;
        logic pend_clr;
        logic enable;
        logic lost_clr;
    } cell_in_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            2'd0:    s = SEL_PEND;
            2'd1:    s = SEL_ENABLE;
            2'd2:    s = SEL_LOST;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_evt_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    input  logic [NUM_SRC-1:0]   pend_q,
    input  logic [NUM_SRC-1:0]   enable_q,
    input  logic [NUM_SRC-1:0]   lost_q,
    output reg_wr_t              wr_req,
    output logic [BUS_W-1:0]     bus_rdata
);

    localparam int PAD_W = BUS_W - NUM_SRC;

    reg_sel_e         sel;
    logic [BUS_W-1:0] rd_mux;

    always_comb begin
        sel                = decode_sel(bus_addr);
        wr_req.pend_clr_we = bus_wr && (sel == SEL_PEND);
        wr_req.enable_we   = bus_wr && (sel == SEL_ENABLE);
        wr_req.lost_clr_we = bus_wr && (sel == SEL_LOST);
        wr_req.data        = bus_wdata;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb begin
                case (sel)
                    SEL_PEND:   rd_mux = {{PAD_W{1'b0}}, pend_q};
                    SEL_ENABLE: rd_mux = {{PAD_W{1'b0}}, enable_q};
                    SEL_LOST:   rd_mux = {{PAD_W{1'b0}}, lost_q};
                    default:    rd_mux = '0;
                endcase
            end
        end else begin : g_full
            always_comb begin
                case (sel)
                    SEL_PEND:   rd_mux = pend_q;
                    SEL_ENABLE: rd_mux = enable_q;
                    SEL_LOST:   rd_mux = lost_q;
                    default:    rd_mux = '0;
                endcase
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    // R10: read data shows the selected register one cycle later
    a_r10_enable_readback: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && sel == SEL_ENABLE) |=> (bus_rdata[NUM_SRC-1:0] == $past(enable_q)));

endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cell_in_t cin,
    output logic     pend_q,
    output logic     lost_q
);

    logic new_loss;
    logic pend_d;
    logic lost_d;

    always_comb begin
        // an event on an already set, enabled, not-being-cleared bit is dropped
        new_loss = cin.evt && pend_q && cin.enable && !cin.pend_clr;
        if (cin.evt)           pend_d = 1'b1;
        else if (cin.pend_clr) pend_d = 1'b0;
        else                   pend_d = pend_q;
        if (new_loss)          lost_d = 1'b1;
        else if (cin.lost_clr) lost_d = 1'b0;
        else                   lost_d = lost_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            lost_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
            lost_q <= lost_d;
        end
    end

    // R1: an event always sets the pending bit
    a_r1_event_sets: assert property (@(posedge clk) disable iff (rst)
        cin.evt |=> pend_q);
    // R3: event wins over a simultaneous clear
    a_r3_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (cin.evt && cin.pend_clr) |=> pend_q);
    // R2: a clear without an event drops the bit
    a_r2_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (cin.pend_clr && !cin.evt) |=> !pend_q);
    // R7: an enabled repeat event is recorded as lost
    a_r7_loss_recorded: assert property (@(posedge clk) disable iff (rst)
        (cin.evt && pend_q && cin.enable && !cin.pend_clr) |=> lost_q);
    // R8: lost bit holds until cleared
    a_r8_lost_sticky: assert property (@(posedge clk) disable iff (rst)
        (lost_q && !cin.lost_clr) |=> lost_q);

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
    import irq_evt_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  reg_wr_t            wr_req,
    output logic [NUM_SRC-1:0] enable_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
        end else if (wr_req.enable_we) begin
            enable_q <= wr_req.data[NUM_SRC-1:0];
        end
    end

    // R4: enable bits only change on an enable write
    a_r4_enable_stable: assert property (@(posedge clk) disable iff (rst)
        !wr_req.enable_we |=> $stable(enable_q));

endmodule

// File: rtl/irq_req_reduce.sv
module irq_req_reduce #(
    parameter int NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0] pend_q,
    input  logic [NUM_SRC-1:0] enable_q,
    output logic               irq_req
);

    logic [NUM_SRC-1:0] live;

    always_comb begin
        live    = pend_q & enable_q;
        irq_req = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            irq_req = irq_req | live[i];
        end
    end

    // R5: no request without an enabled pending source
    always_comb begin
        a_r5_req_has_source: assert (!irq_req || ($countones(live) > 0));
    end

endmodule

// File: rtl/irq_event_collector.sv
module irq_event_collector
    import irq_evt_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_in,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [1:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_req
);

    reg_wr_t            wr_req;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] lost_q;

    irq_reg_port #(.NUM_SRC(NUM_SRC)) i_port (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pend_q    (pend_q),
        .enable_q  (enable_q),
        .lost_q    (lost_q),
        .wr_req    (wr_req),
        .bus_rdata (bus_rdata)
    );

    irq_enable_reg #(.NUM_SRC(NUM_SRC)) i_enable (
        .clk      (clk),
        .rst      (rst),
        .wr_req   (wr_req),
        .enable_q (enable_q)
    );

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
            cell_in_t cin;
            always_comb begin
                cin.evt      = evt_in[g];
                cin.pend_clr = wr_req.pend_clr_we && wr_req.data[g];
                cin.enable   = enable_q[g];
                cin.lost_clr = wr_req.lost_clr_we && wr_req.data[g];
            end
            irq_src_cell i_cell (
                .clk    (clk),
                .rst    (rst),
                .cin    (cin),
                .pend_q (pend_q[g]),
                .lost_q (lost_q[g])
            );
        end
    endgenerate

    irq_req_reduce #(.NUM_SRC(NUM_SRC)) i_reduce (
        .pend_q   (pend_q),
        .enable_q (enable_q),
        .irq_req  (irq_req)
    );

    // R6: enabling an already pending source raises the request at once
    a_r6_enable_pending: assert property (@(posedge clk) disable iff (rst)
        (wr_req.enable_we && |(wr_req.data[NUM_SRC-1:0] & pend_q)) |=> irq_req);
    // R9: request is low right after reset
    a_r9_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !irq_req);

endmodule

// File: tb/test_irq_event_collector.sv
module test_irq_event_collector;

    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  evt_in = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_req;

    int    n_checks = 0;
    int    n_fail   = 0;
    string phase    = "R9";
    bit    done     = 1'b0;

    irq_event_collector #(.NUM_SRC(N)) i_irq_event_collector (
        .clk(clk), .rst(rst), .evt_in(evt_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req)
    );

    always #5 clk = ~clk;

    // behavioural reference state
    bit [31:0] m_pend, m_en, m_lost, exp_rdata;
    bit        exp_rd_valid;

    function automatic bit [31:0] model_read(input int a);
        case (a)
            0: return m_pend;
            1: return m_en;
            2: return m_lost;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check_eq(input string req, input string what, input bit [31:0] act, input bit [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_pend = 0; m_en = 0; m_lost = 0; exp_rd_valid = 0;
        end else begin
            bit [31:0] np, ne, nl;
            exp_rd_valid = bus_rd;
            if (bus_rd) exp_rdata = model_read(int'(bus_addr));
            np = m_pend; ne = m_en; nl = m_lost;
            for (int i = 0; i < N; i++) begin
                bit ev, pc, lc;
                ev = evt_in[i];
                pc = bus_wr && bus_addr == 2'd0 && bus_wdata[i];
                lc = bus_wr && bus_addr == 2'd2 && bus_wdata[i];
                if (ev) np[i] = 1; else if (pc) np[i] = 0;
                if (ev && m_pend[i] && m_en[i] && !pc) nl[i] = 1;
                else if (lc) nl[i] = 0;
                if (bus_wr && bus_addr == 2'd1) ne[i] = bus_wdata[i];
            end
            m_pend = np; m_en = ne; m_lost = nl;
        end
    end

    // compare outputs on every falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check_eq(phase, "irq_req", {31'd0, irq_req}, {31'd0, |(m_pend & m_en)});
            if (exp_rd_valid) check_eq(phase, "bus_rdata", bus_rdata, exp_rdata);
        end
    end

    task automatic cycle(input bit wr, input bit rd, input int addr, input bit [31:0] data, input bit [N-1:0] ev);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = 2'(addr); bus_wdata = data; evt_in = ev;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; evt_in = '0;
    endtask

    task automatic rd_reg(input int addr, output bit [31:0] val);
        cycle(0, 1, addr, 0, '0);
        val = bus_rdata;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bit [31:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        // R9 reset state
        phase = "R9";
        check_eq("R9", "irq_req after reset", {31'd0, irq_req}, 0);
        rd_reg(0, v); check_eq("R9", "pending reset", v, 0);
        rd_reg(1, v); check_eq("R9", "enable reset", v, 0);
        rd_reg(2, v); check_eq("R9", "lost reset", v, 0);

        // R1 events latch while masked
        phase = "R1";
        cycle(0, 0, 0, 0, 8'h09);
        check_eq("R1", "irq masked", {31'd0, irq_req}, 0);
        rd_reg(0, v); check_eq("R1", "pending latched while masked", v, 32'h09);
        cycle(0, 0, 0, 0, 8'h09);  // masked repeat, no loss
        rd_reg(2, v); check_eq("R7", "no loss when masked", v, 0);

        // R6 enabling pending source raises request next edge
        phase = "R6";
        cycle(1, 0, 1, 32'h08, '0);
        check_eq("R6", "irq after enable", {31'd0, irq_req}, 1);

        // R2 write 0 ignored, write 1 clears
        phase = "R2";
        cycle(1, 0, 0, 32'h0, '0);
        rd_reg(0, v); check_eq("R2", "zero write keeps", v, 32'h09);
        check_eq("R5", "irq still held", {31'd0, irq_req}, 1);
        cycle(1, 0, 0, 32'h08, '0);
        phase = "R5";
        check_eq("R5", "irq drops when enabled flag cleared", {31'd0, irq_req}, 0);
        rd_reg(0, v); check_eq("R2", "bit3 cleared", v, 32'h01);

        // R4 enable is a plain mask
        phase = "R4";
        cycle(1, 0, 1, 32'h21, '0);
        check_eq("R4", "irq with bit0 enabled", {31'd0, irq_req}, 1);
        rd_reg(0, v); check_eq("R4", "enable write leaves pending", v, 32'h01);
        cycle(1, 0, 1, 32'h20, '0);
        check_eq("R4", "irq masked again", {31'd0, irq_req}, 0);

        // R3 event vs clear, R7 loss
        phase = "R3";
        cycle(0, 0, 0, 0, 8'h20);
        cycle(1, 0, 0, 32'h20, 8'h20);
        rd_reg(0, v); check_eq("R3", "event beats clear", v, 32'h21);
        rd_reg(2, v); check_eq("R7", "no loss on clear+event", v, 0);
        phase = "R7";
        cycle(0, 0, 0, 0, 8'h21);
        rd_reg(2, v); check_eq("R7", "loss on enabled repeat only", v, 32'h20);

        // R8 sticky, zero write ignored, new loss beats clear
        phase = "R8";
        cycle(1, 0, 2, 32'h0, '0);
        rd_reg(2, v); check_eq("R8", "zero write keeps lost", v, 32'h20);
        cycle(1, 0, 2, 32'h20, 8'h20);
        rd_reg(2, v); check_eq("R8", "new loss beats clear", v, 32'h20);
        cycle(1, 0, 2, 32'h20, '0);
        rd_reg(2, v); check_eq("R8", "lost cleared", v, 0);

        // R10 offsets, padding, unused offset
        phase = "R10";
        cycle(1, 0, 1, 32'hFFFF_FFFF, '0);
        rd_reg(1, v); check_eq("R10", "upper bits read zero", v, 32'hFF);
        cycle(1, 0, 3, 32'hFFFF_FFFF, '0);
        rd_reg(3, v); check_eq("R10", "offset 3 reads zero", v, 0);
        rd_reg(0, v); check_eq("R10", "offset 3 write ignored", v, 32'h21);

        // mixed traffic against the model (R1 R2 R3 R4 R5 R7 R8 R10)
        phase = "R1..R8 mixed";
        for (int k = 0; k < 400; k++) begin
            bit [N-1:0] ev;
            ev = N'($urandom) & N'($urandom);
            cycle($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 0,
                  $urandom_range(0, 3), $urandom, ev);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule